// File: doc/BRIEF.md
# Shared-Address Dual-Port Register-File RAM

This block is a small distributed memory of 2^ADDR_W words with one write port and two read ports. A single primary address selects the word that a write lands in, and also selects the word shown on the first read output. A second address, used only for reading, selects the word shown on the second read output. Both read outputs are combinational. Each also has a registered copy that is updated on every rising clock edge.

Internally each data bit is a slice made of two storage copies. The two copies are always written together from the primary address. One copy serves the primary read port and the other serves the secondary read port, so the secondary port can look at any word while a write is going on. Wider words are built by replicating the slice once per bit. A typical use is a small queue: the producer writes through the primary address and the consumer reads through the secondary address in the same cycle.

Top module: `dpram_shared_addr`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (16 words by default). Every word reads as zero at start-up.
- R2: On a rising edge of clk_i with we_i high, din_i is stored at address addr_i. Both read ports then return it for that address.
- R3: On a rising edge with we_i low, no word changes, whatever din_i holds.
- R4: spo_o always shows, combinationally, the word at addr_i.
- R5: dpo_o always shows, combinationally, the word at dp_addr_i.
- R6: When a write and a read hit the same address in one cycle, the combinational output shows the old word before the edge and the new word right after it.
- R7: On each rising edge, spo_q_o and dpo_q_o take the values that spo_o and dpo_o had just before that edge.
- R8: While rst_ni is low, spo_q_o and dpo_q_o are held at zero with no clock needed. Stored words are not affected by reset.
- R9: The two storage copies always agree: when addr_i equals dp_addr_i, spo_o equals dpo_o.
- R10: Each bit of a word is stored independently. A written pattern with mixed ones and zeros reads back bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Write and output-register clock |
| rst_ni | input | 1 | Active-low asynchronous clear of the output registers |
| we_i | input | 1 | Write enable, sampled at the rising edge |
| din_i | input | DATA_W | Write data |
| addr_i | input | ADDR_W | Write address and primary read address |
| dp_addr_i | input | ADDR_W | Secondary read address |
| spo_o | output | DATA_W | Combinational word at addr_i |
| dpo_o | output | DATA_W | Combinational word at dp_addr_i |
| spo_q_o | output | DATA_W | Registered spo_o |
| dpo_q_o | output | DATA_W | Registered dpo_o |

## Verification
The assertions assume that addresses, data and the write enable change only between clock edges. They also assume that reset is released away from an edge, so the value sampled at one edge describes the whole following cycle. The bench drives every input on the falling edge and releases reset there too. It checks the combinational outputs one nanosecond later and checks the registered outputs one nanosecond after the rising edge, so no sample falls in the window where inputs are still settling.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned DATA_W_DEF = 1;

  function automatic int unsigned depth_of(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/dpram_copy.sv
// One 2^ADDR_W x 1 storage copy: edge-triggered write, asynchronous read.
module dpram_copy #(
  parameter int unsigned ADDR_W = dpram_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              d_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              q_o
);
  localparam int unsigned DEPTH = dpram_pkg::depth_of(ADDR_W);

  logic [DEPTH-1:0] mem_q = '0;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= d_i;
  end

  assign q_o = mem_q[raddr_i];
endmodule

// File: rtl/dpram_slice.sv
// One bit of the word: two mirrored copies written in lockstep.
module dpram_slice #(
  parameter int unsigned ADDR_W = dpram_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              d_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] dp_addr_i,
  output logic              spo_o,
  output logic              dpo_o
);
  dpram_copy #(.ADDR_W(ADDR_W)) u_copy_sp (
    .clk_i   (clk_i),
    .we_i    (we_i),
    .d_i     (d_i),
    .waddr_i (addr_i),
    .raddr_i (addr_i),
    .q_o     (spo_o)
  );

  dpram_copy #(.ADDR_W(ADDR_W)) u_copy_dp (
    .clk_i   (clk_i),
    .we_i    (we_i),
    .d_i     (d_i),
    .waddr_i (addr_i),
    .raddr_i (dp_addr_i),
    .q_o     (dpo_o)
  );
endmodule

// File: rtl/dpram_out_reg.sv
module dpram_out_reg #(
  parameter int unsigned W = dpram_pkg::DATA_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/dpram_shared_addr.sv
module dpram_shared_addr #(
  parameter int unsigned ADDR_W = dpram_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = dpram_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] dp_addr_i,
  output logic [DATA_W-1:0] spo_o,
  output logic [DATA_W-1:0] dpo_o,
  output logic [DATA_W-1:0] spo_q_o,
  output logic [DATA_W-1:0] dpo_q_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    dpram_slice #(.ADDR_W(ADDR_W)) u_slice (
      .clk_i     (clk_i),
      .we_i      (we_i),
      .d_i       (din_i[b]),
      .addr_i    (addr_i),
      .dp_addr_i (dp_addr_i),
      .spo_o     (spo_o[b]),
      .dpo_o     (dpo_o[b])
    );
  end

  dpram_out_reg #(.W(DATA_W)) u_spo_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (spo_o),
    .q_o    (spo_q_o)
  );

  dpram_out_reg #(.W(DATA_W)) u_dpo_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dpo_o),
    .q_o    (dpo_q_o)
  );
endmodule

// File: rtl/dpram_shared_addr_chk.sv
module dpram_shared_addr_chk #(
  parameter int unsigned ADDR_W = dpram_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = dpram_pkg::DATA_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [DATA_W-1:0] din_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] dp_addr_i,
  input logic [DATA_W-1:0] spo_o,
  input logic [DATA_W-1:0] dpo_o,
  input logic [DATA_W-1:0] spo_q_o,
  input logic [DATA_W-1:0] dpo_q_o
);
  // R2: the written word is visible on the primary port next cycle if the address holds
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((addr_i != $past(addr_i)) || (spo_o == $past(din_i))));

  // R2: the mirror copy sees the same write
  a_r2_mirror_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((dp_addr_i != $past(addr_i)) || (dpo_o == $past(din_i))));

  // R3: no write and a steady address leave the primary output unchanged
  a_r3_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (!$stable(addr_i) || $stable(spo_o)));

  // R7: registered outputs follow the pre-edge combinational values
  a_r7_spo_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (spo_q_o == $past(spo_o)));
  a_r7_dpo_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dpo_q_o == $past(dpo_o)));

  // R8: registered outputs are clear while reset is held
  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (spo_q_o == '0 && dpo_q_o == '0));

  // R9: both copies agree on a shared address
  a_r9_copies_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == dp_addr_i) |-> (spo_o == dpo_o));
endmodule

bind dpram_shared_addr dpram_shared_addr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpram_shared_addr_test.sv
`timescale 1ns/1ps
module dpram_shared_addr_test;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 4;
  localparam int unsigned DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] addr = '0, dp_addr = '0;
  logic [DW-1:0] spo, dpo, spo_q, dpo_q;

  logic [DW-1:0] ref_mem [DEPTH];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpram_shared_addr #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .din_i(din),
    .addr_i(addr), .dp_addr_i(dp_addr),
    .spo_o(spo), .dpo_o(dpo), .spo_q_o(spo_q), .dpo_q_o(dpo_q)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return ref_mem[a];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check pre-edge, then registers and post-edge.
  task automatic cycle(input logic w, input logic [DW-1:0] d,
                       input logic [AW-1:0] a, input logic [AW-1:0] da);
    logic [DW-1:0] pre_sp, pre_dp;
    @(negedge clk);
    we = w; din = d; addr = a; dp_addr = da;
    #1;
    pre_sp = exp_rd(a);
    pre_dp = exp_rd(da);
    chk("R4/R6 spo pre-edge", spo, pre_sp);
    chk("R5 dpo pre-edge", dpo, pre_dp);
    if (a == da) chk("R9 copies agree", dpo, spo);
    @(posedge clk);
    if (w) ref_mem[a] = d;
    #1;
    chk("R7 spo_q", spo_q, pre_sp);
    chk("R7 dpo_q", dpo_q, pre_dp);
    chk("R2/R3/R6 spo post-edge", spo, exp_rd(a));
    chk("R2/R10 dpo post-edge", dpo, exp_rd(da));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

    // R8: registered outputs clear in reset
    #1;
    chk("R8 spo_q in reset", spo_q, '0);
    chk("R8 dpo_q in reset", dpo_q, '0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;

    // R1: all words start at zero
    for (int i = 0; i < DEPTH; i++) cycle(1'b0, '1, AW'(i), AW'(DEPTH - 1 - i));

    // R10: mixed bit patterns
    cycle(1'b1, 4'b1010, 4'd3, 4'd3);
    cycle(1'b1, 4'b0101, 4'd4, 4'd3);
    cycle(1'b0, 4'b1111, 4'd4, 4'd3);

    // R6: same-address collision on both ports
    cycle(1'b1, 4'b1100, 4'd3, 4'd3);
    // R3: write enable low, data differs
    cycle(1'b0, 4'b0011, 4'd3, 4'd4);
    // R2: boundary addresses
    cycle(1'b1, 4'hf, 4'd15, 4'd0);
    cycle(1'b1, 4'h9, 4'd0, 4'd15);
    cycle(1'b0, 4'h0, 4'd15, 4'd0);

    // Random mix with frequent collisions
    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] a, da;
      a  = AW'($urandom_range(0, DEPTH - 1));
      da = ($urandom_range(0, 3) == 0) ? a : AW'($urandom_range(0, DEPTH - 1));
      cycle(1'($urandom_range(0, 1)), DW'($urandom), a, da);
    end

    // R8: mid-run reset clears registers without a clock, keeps storage
    @(negedge clk);
    we = 1'b0;
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    chk("R8 spo_q async clear", spo_q, '0);
    chk("R8 dpo_q async clear", dpo_q, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) cycle(1'b0, '0, AW'(i), AW'(i));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule